// File: doc/BRIEF.md
# SDI Receive Deserializer and Word Framer

This block turns a recovered serial video bit stream into 10-bit parallel words. Each received bit arrives with a one-cycle bit enable in the system clock domain, and ten enabled bits make one word. By default the bit first goes through an NRZI decoder (each output bit is the current line bit XOR the previous line bit). The result then passes through a self-synchronising descrambler with the generator x^9 + x^4 + 1. The decoded bits, least significant bit first, feed a word framer. The framer looks for the timing reference preamble, which is one word of all ones followed by two words of all zeros. When it finds a preamble it moves the word boundary so that the word after it, the identifier, ends a word.

The framer drives a horizontal active-video flag from bit 6 of each identifier. It also drives a lock flag, which rises when reference codes keep landing on the same word boundary and falls when one lands elsewhere. A single decode-bypass control sends raw line bits straight to the framer, skipping both the NRZI decoder and the descrambler. While the bypass is high the active-video flag is frozen.

The parallel side is a source-timed stream. `word_valid` is a one-cycle pulse carrying `word_data`. There is no ready input, because the serial source cannot be paused, so the consumer must take every pulse in the cycle it occurs. Between pulses `word_data` holds its last value.

Top module: `sdi_rx_framer`

## Requirements
- R1: `word_valid` pulses for one cycle, one clock after the edge that takes the 10th bit of a word. Bits fill the word from bit 0 upward, so the first received bit lands in bit 0.
- R2: With `decode_bypass` low, the first stage outputs each line bit XOR the previous line bit. That previous bit is 0 after reset.
- R3: The first stage's output d[n] is descrambled to d[n] ^ d[n-4] ^ d[n-9], with history that is 0 after reset. The descrambler history shifts on every enabled bit, in both modes.
- R4: A reference code is the decoded bit sequence 0x3FF, 0x000, 0x000 followed by an identifier word. When the identifier's last bit arrives, the identifier is output as a word, even if the old boundary had not reached 10 bits, and the next bit starts a new word.
- R5: With `decode_bypass` low, each identifier sets `h_active` to its bit 6: 1 for an end-of-active-video code (e.g. 0x274) and 0 for a start-of-active-video code (e.g. 0x200).
- R6: `locked` rises when a reference code ends exactly on the existing boundary and the reference code before it did too. The count of such codes restarts at 1 whenever a code forces a realignment.
- R7: A reference code whose identifier does not end on the existing word boundary clears `locked` in the same cycle that it realigns.
- R8: With `decode_bypass` high, line bits reach the framer unchanged, and identifiers leave `h_active` at its previous value.
- R9: During reset `word_valid`, `word_data` and `locked` are 0 and `h_active` is 1.
- R10: Cycles with `bit_en` low change nothing: no word is output and `locked`, `h_active` and `word_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One received bit is present this cycle |
| bit_in | input | 1 | Received line bit, valid with `bit_en` |
| decode_bypass | input | 1 | High: skip NRZI decode and descrambling, and freeze `h_active` |
| word_valid | output | 1 | One-cycle strobe for `word_data`; there is no back-pressure |
| word_data | output | 10 | Parallel word, first received bit in bit 0 |
| h_active | output | 1 | Active-video flag: 0 after a start-of-active-video identifier, 1 after an end-of-active-video identifier |
| locked | output | 1 | Word boundary confirmed by consecutive aligned reference codes |

## Verification
The bench inserts a single extra bit into the stream. A framer that failed to realign would keep giving shifted words and keep `locked` high. One that realigned without emitting the identifier, or that did not restart its lock count, would show up in the words and the lock flag around the slip. The stimulus leaves gaps in `bit_en` and toggles the line bit during them. A design that counted or shifted on idle cycles would then misframe or produce extra strobes. The bench also switches to bypass with an identifier whose bit 6 disagrees with the current flag. A design that let H follow identifiers in bypass would flip the flag, and one that still decoded the bits would turn the raw words into garbage.

// File: rtl/sdi_rx_pkg.sv
`timescale 1ns/1ps
package sdi_rx_pkg;
  localparam int WORD_W      = 10;
  localparam int PRE_WORDS   = 3;
  localparam int SCR_TAP_LO  = 4;
  localparam int SCR_TAP_HI  = 9;
  localparam int ID_FLAG_BIT = 6;
  localparam int LOCK_CODES  = 2;

  // Preamble test on a window whose bit 0 is the oldest bit.
  function automatic logic preamble_at(input logic [PRE_WORDS*WORD_W-1:0] win);
    logic ones_ok;
    logic zeros_ok;
    ones_ok  = &win[WORD_W-1:0];
    zeros_ok = ~|win[PRE_WORDS*WORD_W-1:WORD_W];
    return ones_ok & zeros_ok;
  endfunction
endpackage

// File: rtl/sdi_nrzi_dec.sv
`timescale 1ns/1ps
module sdi_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bypass,
  input  logic din,
  output logic dout
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  prev_q <= 1'b0;
    else if (en) prev_q <= din;
  end

  assign dout = bypass ? din : (din ^ prev_q);
endmodule

// File: rtl/sdi_descrambler.sv
`timescale 1ns/1ps
module sdi_descrambler #(
  parameter int TAP_LO = sdi_rx_pkg::SCR_TAP_LO,
  parameter int TAP_HI = sdi_rx_pkg::SCR_TAP_HI
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bypass,
  input  logic din,
  output logic dout
);
  // hist_q[0] is the most recent input bit
  logic [TAP_HI-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  hist_q <= '0;
    else if (en) hist_q <= {hist_q[TAP_HI-2:0], din};
  end

  assign dout = bypass ? din : (din ^ hist_q[TAP_LO-1] ^ hist_q[TAP_HI-1]);
endmodule

// File: rtl/sdi_word_framer.sv
`timescale 1ns/1ps
module sdi_word_framer #(
  parameter int W         = sdi_rx_pkg::WORD_W,
  parameter int PRE_WORDS = sdi_rx_pkg::PRE_WORDS,
  parameter int FLAG_BIT  = sdi_rx_pkg::ID_FLAG_BIT,
  parameter int LOCK_N    = sdi_rx_pkg::LOCK_CODES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  input  logic         h_hold,
  output logic         word_valid,
  output logic [W-1:0] word_data,
  output logic         h_active,
  output logic         locked
);
  localparam int SPAN  = (PRE_WORDS + 1) * W;
  localparam int CNT_W = $clog2(W);
  localparam int RUN_W = $clog2(LOCK_N + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
  localparam logic [RUN_W-1:0] RUN_GOAL = RUN_W'(LOCK_N);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  logic [SPAN-2:0]  hist_q;
  logic [SPAN-1:0]  window;
  logic [W-1:0]     newest;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;
  logic             code_hit;
  logic             on_edge;
  logic             word_end;

  assign window   = {din, hist_q};
  assign newest   = window[SPAN-1 -: W];
  assign code_hit = en & sdi_rx_pkg::preamble_at(window[PRE_WORDS*W-1:0]);
  assign on_edge  = (cnt_q == LAST_BIT);
  assign word_end = en & (on_edge | code_hit);
  assign run_inc  = (run_q < RUN_GOAL) ? run_q + 1'b1 : run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q     <= '0;
      cnt_q      <= '0;
      run_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      h_active   <= 1'b1;
      locked     <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (en) begin
        hist_q <= window[SPAN-1:1];
        if (word_end) begin
          cnt_q      <= '0;
          word_valid <= 1'b1;
          word_data  <= newest;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (code_hit) begin
          if (on_edge) begin
            run_q  <= run_inc;
            locked <= (run_inc >= RUN_GOAL);
          end else begin
            run_q  <= RUN_ONE;
            locked <= 1'b0;
          end
          if (!h_hold) h_active <= newest[FLAG_BIT];
        end
      end
    end
  end

  a_r1_strobe_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(en));
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT);
  a_r6_lock_rise_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(code_hit && on_edge));
  a_r7_lock_fall_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(code_hit && !on_edge));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!word_valid && $stable(locked) && $stable(h_active) && $stable(word_data)));
endmodule

// File: rtl/sdi_rx_framer.sv
`timescale 1ns/1ps
module sdi_rx_framer #(
  parameter int W = sdi_rx_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  input  logic         decode_bypass,
  output logic         word_valid,
  output logic [W-1:0] word_data,
  output logic         h_active,
  output logic         locked
);
  logic line_dec;
  logic plain_bit;

  sdi_nrzi_dec u_nrzi (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .bypass(decode_bypass),
    .din(bit_in), .dout(line_dec)
  );

  sdi_descrambler u_descr (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .bypass(decode_bypass),
    .din(line_dec), .dout(plain_bit)
  );

  sdi_word_framer #(.W(W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(bit_en), .din(plain_bit),
    .h_hold(decode_bypass), .word_valid(word_valid), .word_data(word_data),
    .h_active(h_active), .locked(locked)
  );

  a_r8_h_frozen_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(decode_bypass) |-> $stable(h_active));
endmodule

// File: tb/sim_sdi_rx_framer.sv
`timescale 1ns/1ps
module sim_sdi_rx_framer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, bit_en, bit_in, decode_bypass;
  logic       word_valid, h_active, locked;
  logic [9:0] word_data;

  sdi_rx_framer u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .decode_bypass(decode_bypass), .word_valid(word_valid),
    .word_data(word_data), .h_active(h_active), .locked(locked)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic       m_last_raw;
  logic       m_dec[$];
  logic       m_win[$];
  int         m_pos, m_run;
  logic       exp_valid, exp_lock, exp_h;
  logic [9:0] exp_data;
  logic       m_n, m_d, m_hit, m_al;
  logic [9:0] m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last_raw = 1'b0;
      m_dec.delete();
      m_win.delete();
      for (int i = 0; i < 40; i++) m_win.push_back(1'b0);
      m_pos = 0; m_run = 0;
      exp_valid = 1'b0; exp_data = '0; exp_lock = 1'b0; exp_h = 1'b1;
    end else begin
      exp_valid = 1'b0;
      if (bit_en) begin
        m_n = decode_bypass ? bit_in : (bit_in ^ m_last_raw);
        m_last_raw = bit_in;
        m_d = m_n;
        if (!decode_bypass) begin
          if (m_dec.size() > 3) m_d = m_d ^ m_dec[3];
          if (m_dec.size() > 8) m_d = m_d ^ m_dec[8];
        end
        m_dec.push_front(m_n);
        if (m_dec.size() > 9) void'(m_dec.pop_back());
        m_win.push_back(m_d);
        void'(m_win.pop_front());
        m_hit = 1'b1;
        for (int i = 0; i < 30; i++) if (m_win[i] != (i < 10)) m_hit = 1'b0;
        for (int i = 0; i < 10; i++) m_w[i] = m_win[30 + i];
        m_al = (m_pos == 9);
        if (m_al || m_hit) begin
          exp_valid = 1'b1; exp_data = m_w; m_pos = 0;
        end else m_pos++;
        if (m_hit) begin
          if (m_al) begin
            if (m_run < 2) m_run++;
            exp_lock = (m_run >= 2);
          end else begin
            m_run = 1; exp_lock = 1'b0;
          end
          if (!decode_bypass) exp_h = m_w[6];
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  logic [9:0] last_word = '0;
  int         nwords = 0;
  always @(negedge clk) begin
    chk(word_valid === exp_valid, "R1 R10 strobe", word_valid, exp_valid);
    if (exp_valid) chk(word_data === exp_data, "R2 R3 R4 word data", word_data, exp_data);
    chk(locked === exp_lock, "R6 R7 lock", locked, exp_lock);
    chk(h_active === exp_h, "R5 R8 h_active", h_active, exp_h);
    if (word_valid) begin
      last_word = word_data;
      nwords++;
    end
  end

  // ---------------- stimulus: encoder side ----------------
  logic enc_c[$];
  logic enc_r = 1'b0;
  bit   enc_mode = 1'b1;
  int   gap_ctr = 0;

  task automatic send_bit(input logic b);
    gap_ctr++;
    if (gap_ctr % 7 == 0) begin
      @(negedge clk); bit_en = 1'b0; bit_in = ~b;
    end
    @(negedge clk); bit_en = 1'b1; bit_in = b;
  endtask

  task automatic send_enc_bit(input logic d);
    logic c;
    c = d;
    if (enc_c.size() > 3) c = c ^ enc_c[3];
    if (enc_c.size() > 8) c = c ^ enc_c[8];
    enc_c.push_front(c);
    if (enc_c.size() > 9) void'(enc_c.pop_back());
    enc_r = enc_r ^ c;
    send_bit(enc_r);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) begin
      if (enc_mode) send_enc_bit(w[i]);
      else send_bit(w[i]);
    end
  endtask

  task automatic send_code(input logic [9:0] id);
    send_word(10'h3FF); send_word(10'h000); send_word(10'h000); send_word(id);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_en = 1'b0; bit_in = i[0];
    end
    #1;
  endtask

  initial begin
    int seen;
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; decode_bypass = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(word_valid === 1'b0, "R9 reset strobe", word_valid, 0);
    chk(word_data === 10'h000, "R9 reset data", word_data, 0);
    chk(locked === 1'b0, "R9 reset lock", locked, 0);
    chk(h_active === 1'b1, "R9 reset h", h_active, 1);
    @(negedge clk); rst_n = 1'b1;

    send_word(10'h155); send_word(10'h2AA); send_word(10'h123);
    idle(3);
    chk(last_word === 10'h123, "R2 R3 decoded word", last_word, 10'h123);

    send_code(10'h274);
    idle(3);
    chk(locked === 1'b0, "R6 one code no lock", locked, 0);
    chk(h_active === 1'b1, "R5 EAV sets h", h_active, 1);
    send_word(10'h040); send_word(10'h3C0);
    send_code(10'h200);
    idle(3);
    chk(locked === 1'b1, "R6 lock after two codes", locked, 1);
    chk(h_active === 1'b0, "R5 SAV clears h", h_active, 0);

    // single-bit slip, then a code at the new boundary
    send_enc_bit(1'b1);
    send_word(10'h155);
    send_code(10'h274);
    idle(3);
    chk(locked === 1'b0, "R7 lock drop on slip", locked, 0);
    chk(last_word === 10'h274, "R4 identifier output at realign", last_word, 10'h274);
    chk(h_active === 1'b1, "R5 EAV after slip", h_active, 1);
    send_word(10'h2AA);
    idle(3);
    chk(last_word === 10'h2AA, "R4 word on new boundary", last_word, 10'h2AA);
    send_code(10'h200);
    idle(3);
    chk(locked === 1'b1, "R6 relock", locked, 1);

    seen = nwords;
    idle(25);
    chk(nwords == seen, "R10 no words while idle", nwords, seen);
    chk(locked === 1'b1, "R10 lock held while idle", locked, 1);

    // raw bypass mode
    @(negedge clk); decode_bypass = 1'b1; enc_mode = 1'b0;
    send_word(10'h0F0);
    send_code(10'h274);
    send_word(10'h1E5);
    idle(3);
    chk(last_word === 10'h1E5, "R8 raw word in bypass", last_word, 10'h1E5);
    chk(h_active === 1'b0, "R8 h held in bypass", h_active, 0);
    chk(locked === 1'b1, "R6 aligned raw code keeps lock", locked, 1);

    finish_run();
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end
endmodule